// File: doc/BRIEF.md
# Radix-16 Recoded Sequential Multiplier

This block multiplies two 32-bit unsigned numbers and returns the 64-bit unsigned product as an upper and a lower word. It works through the multiplier one 4-bit digit per clock, least significant digit first. Each digit selects a small multiple of the multiplicand. The multiple is added to a signed accumulator, and the four low bits of the sum are then shifted out into a lower-word register. Digits from 11 to 15 are recoded as the digit minus 16. The multiple is then subtracted, and a carry goes into the next digit. This keeps every multiple between -5 and +10 times the multiplicand.

The loop runs on a 31-bit multiplicand. When the top bit of the multiplicand is set, that bit is cleared for the loop. A final cycle then adds the multiplier shifted left by 31 into the product. The same final cycle first adds the multiplicand to the upper word when a carry is still pending after the last digit. A zero multiplicand skips the loop and completes at once.

Software or a controller pulses `start` with the operands while `busy` is low. It then waits for the one-cycle `done` pulse and reads the registered product, which stays unchanged until the next completion.

Top module: `radix16_mult`

## Requirements
- R1: After each completed operation, {prod_hi, prod_lo} equals mcand times mplier as a 64-bit unsigned value, with prod_hi the upper 32 bits.
- R2: When start is sampled high with busy low and mcand non-zero, busy is high for the next 9 cycles. done is high in the cycle that starts at the 9th rising edge after the accepting edge. busy is low in that cycle.
- R3: When start is sampled high with busy low and mcand equal to zero, done is high and the product is zero in the cycle after the accepting edge, and busy stays low.
- R4: Multiplier digits of value 11 to 15, including digits that become 16 through an incoming carry, are handled by subtracting a multiple and carrying one into the next digit, and still give the exact product (for example, multiplier 0xFFFFFFFF).
- R5: A carry still pending after the eighth digit is resolved by adding the multiplicand once more into the upper word (for example, multiplier 0xF0000000).
- R6: A multiplicand with bit 31 set gives the exact product, including the case where bit 31 is the only bit set.
- R7: start is ignored while busy is high. Operand values presented with it do not change the running result, and no extra done pulse follows.
- R8: done is high for exactly one cycle per accepted operation. prod_hi and prod_lo change only in the cycle where done is high.
- R9: After reset, busy and done are low and prod_hi and prod_lo are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiplication |
| mcand | input | 32 | Multiplicand, sampled with start |
| mplier | input | 32 | Multiplier, sampled with start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| prod_hi | output | 32 | Upper word of the product |
| prod_lo | output | 32 | Lower word of the product |

## Verification
The hardest path to reach is the one where the accumulator goes negative and a carry is still pending at the end. On that path the last digit has been recoded to a negative multiple, and the final cycle must combine the extra multiplicand addition with the bit-31 correction. Random operands seldom line up a top digit of 11 or more with a set multiplicand MSB. The stimulus therefore builds multipliers from chosen digits: all-ones, a lone top digit of 0xF or 0xB, and alternating 0xC/0x4 patterns. These are paired with multiplicands that have bit 31 set, 0x80000000 alone, and 0xFFFFFFFF.

// File: rtl/r16m_pkg.sv
package r16m_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_FIN  = 2'd2
    } r16m_state_e;
endpackage

// File: rtl/r16m_recode.sv
// Turns one multiplier digit plus incoming carry into a sign, a magnitude
// and an outgoing carry. Values at or above THR become (value - 2**DIG).
module r16m_recode #(
    parameter int DIG = 4,
    parameter int THR = 11
) (
    input  logic [DIG-1:0] digit,
    input  logic           cin,
    output logic           neg,
    output logic [DIG-1:0] mag,
    output logic           cout
);
    localparam logic [DIG:0] RADIX = (DIG+1)'(1 << DIG);
    localparam logic [DIG:0] THR_V = (DIG+1)'(THR);

    logic [DIG:0] value;
    logic [DIG:0] compl;

    always_comb begin
        value = {1'b0, digit} + {{DIG{1'b0}}, cin};
        compl = RADIX - value;
        if (value >= THR_V) begin
            neg  = 1'b1;
            mag  = compl[DIG-1:0];
            cout = 1'b1;
        end else begin
            neg  = 1'b0;
            mag  = value[DIG-1:0];
            cout = 1'b0;
        end
    end
endmodule

// File: rtl/r16m_multiple.sv
// Forms +/- mag * a as a signed accumulator-width term.
module r16m_multiple #(
    parameter int W     = 32,
    parameter int DIG   = 4,
    parameter int ACC_W = 38
) (
    input  logic [W-1:0]            a,
    input  logic [DIG-1:0]          mag,
    input  logic                    neg,
    output logic signed [ACC_W-1:0] term
);
    logic [ACC_W-1:0] part [DIG];
    logic [ACC_W-1:0] pos;

    for (genvar i = 0; i < DIG; i++) begin : g_part
        assign part[i] = mag[i] ? ({{(ACC_W-W){1'b0}}, a} << i) : '0;
    end

    always_comb begin
        pos = '0;
        for (int i = 0; i < DIG; i++) begin
            pos = pos + part[i];
        end
        term = neg ? -$signed(pos) : $signed(pos);
    end
endmodule

// File: rtl/r16m_fixup.sv
// Final cycle: pending-carry addition to the upper word, then the
// bit-31 correction of the multiplier shifted by W-1.
module r16m_fixup #(
    parameter int W = 32
) (
    input  logic [W-1:0] upper,
    input  logic [W-1:0] lower,
    input  logic         cy,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         msb,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    logic [W-1:0]   up_adj;
    logic [2*W-1:0] corr;
    logic [2*W-1:0] full;

    always_comb begin
        up_adj = upper + (cy ? a : '0);
        corr   = msb ? ({{W{1'b0}}, b} << (W-1)) : '0;
        full   = {up_adj, lower} + corr;
        hi     = full[2*W-1:W];
        lo     = full[W-1:0];
    end
endmodule

// File: rtl/radix16_mult.sv
module radix16_mult #(
    parameter int W   = 32,
    parameter int DIG = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] mcand,
    input  logic [W-1:0] mplier,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] prod_lo
);
    import r16m_pkg::*;

    localparam int STEPS = W / DIG;
    localparam int CW    = $clog2(STEPS + 1);
    localparam int THR   = (3 << (DIG - 2)) - 1;
    localparam int ACC_W = W + DIG + 2;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    typedef struct packed {
        r16m_state_e             st;
        logic [CW-1:0]           cnt;
        logic signed [ACC_W-1:0] acc;
        logic [W-1:0]            lo;
        logic [W-1:0]            a;
        logic [W-1:0]            b;
        logic [W-1:0]            bsh;
        logic                    msb;
        logic                    cy;
        logic                    busy;
        logic                    done;
        logic [W-1:0]            hi_o;
        logic [W-1:0]            lo_o;
    } regs_t;

    regs_t r_q, r_d;

    logic                    dg_neg, dg_cout;
    logic [DIG-1:0]          dg_mag;
    logic signed [ACC_W-1:0] term;
    logic signed [ACC_W-1:0] sum;
    logic [W-1:0]            fx_hi, fx_lo;

    r16m_recode #(.DIG(DIG), .THR(THR)) u_recode (
        .digit (r_q.bsh[DIG-1:0]),
        .cin   (r_q.cy),
        .neg   (dg_neg),
        .mag   (dg_mag),
        .cout  (dg_cout)
    );

    r16m_multiple #(.W(W), .DIG(DIG), .ACC_W(ACC_W)) u_multiple (
        .a    (r_q.a),
        .mag  (dg_mag),
        .neg  (dg_neg),
        .term (term)
    );

    r16m_fixup #(.W(W)) u_fixup (
        .upper (r_q.acc[W-1:0]),
        .lower (r_q.lo),
        .cy    (r_q.cy),
        .a     (r_q.a),
        .b     (r_q.b),
        .msb   (r_q.msb),
        .hi    (fx_hi),
        .lo    (fx_lo)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        sum      = r_q.acc + term;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (mcand == '0) begin
                        r_d.hi_o = '0;
                        r_d.lo_o = '0;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.a    = {1'b0, mcand[W-2:0]};
                        r_d.msb  = mcand[W-1];
                        r_d.b    = mplier;
                        r_d.bsh  = mplier;
                        r_d.acc  = '0;
                        r_d.lo   = '0;
                        r_d.cy   = 1'b0;
                        r_d.cnt  = '0;
                        r_d.busy = 1'b1;
                        r_d.st   = ST_STEP;
                    end
                end
            end
            ST_STEP: begin
                r_d.acc = sum >>> DIG;
                r_d.lo  = {sum[DIG-1:0], r_q.lo[W-1:DIG]};
                r_d.bsh = r_q.bsh >> DIG;
                r_d.cy  = dg_cout;
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST) begin
                    r_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                r_d.hi_o = fx_hi;
                r_d.lo_o = fx_lo;
                r_d.done = 1'b1;
                r_d.busy = 1'b0;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = r_q.busy;
    assign done    = r_q.done;
    assign prod_hi = r_q.hi_o;
    assign prod_lo = r_q.lo_o;
endmodule

// File: rtl/radix16_mult_chk.sv
module radix16_mult_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] mcand,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] prod_hi,
    input logic [W-1:0] prod_lo
);
    logic [3:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else run_q <= '0;
    end

    // R2: a run never exceeds nine busy cycles
    p_run_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q <= 4'd8));

    // R2: end of a run is marked by done
    p_end_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R2: accepted non-zero request raises busy
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mcand != '0) |=> busy);

    // R3: zero multiplicand completes next cycle with zero product
    p_zero_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mcand == '0) |=> (done && !busy && prod_hi == '0 && prod_lo == '0));

    // R8: done and busy never overlap
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: product only moves with done
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(prod_hi) && $stable(prod_lo)));
endmodule

bind radix16_mult radix16_mult_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mcand   (mcand),
    .busy    (busy),
    .done    (done),
    .prod_hi (prod_hi),
    .prod_lo (prod_lo)
);

// File: tb/tb_radix16_mult.sv
`timescale 1ns/1ps
module tb_radix16_mult;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] mcand = '0;
    logic [31:0] mplier = '0;
    logic        busy, done;
    logic [31:0] prod_hi, prod_lo;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] exp_q [$];
    logic [63:0] last_exp = '0;

    always #2.5 clk = ~clk;

    radix16_mult dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
        .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Monitor: pops expected products as done pulses appear (R1, R7)
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected done", {prod_hi, prod_lo}, 64'd0);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                check({prod_hi, prod_lo} == e, "R1 product", {prod_hi, prod_lo}, e);
            end
        end
    end

    // Driver: issue one operation, check latency and hold behaviour
    task automatic do_mul(input logic [31:0] a, input logic [31:0] b,
                          input string req, input bit disturb);
        int n;
        int want;
        logic [63:0] e;
        @(negedge clk);
        while (busy) @(negedge clk);
        e = 64'(a) * 64'(b);
        exp_q.push_back(e);
        mcand = a; mplier = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        if (a == 0) check(!busy, "R3 busy stays low", 64'(busy), 64'd0);
        while (!done && n < 40) begin
            if (disturb && n == 3) begin
                mcand = ~a; mplier = b ^ 32'h5A5A_A5A5; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        want = (a == 0) ? 1 : 10;
        check(n == want, (a == 0) ? "R3 latency" : "R2 latency", 64'(n), 64'(want));
        check({prod_hi, prod_lo} == e, req, {prod_hi, prod_lo}, e);
        @(negedge clk);
        check(!done, "R8 done single cycle", 64'(done), 64'd0);
        check({prod_hi, prod_lo} == e, "R8 product held", {prod_hi, prod_lo}, e);
        last_exp = e;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(!busy, "R9 busy", 64'(busy), 64'd0);
        check(!done, "R9 done", 64'(done), 64'd0);
        check({prod_hi, prod_lo} == 64'd0, "R9 product", {prod_hi, prod_lo}, 64'd0);
        rst_n = 1'b1;

        do_mul(32'd3, 32'd5, "R1 small", 1'b0);
        do_mul(32'd0, 32'h1234_5678, "R3 zero mcand", 1'b0);
        do_mul(32'h1234_5678, 32'd0, "R1 zero mplier", 1'b0);
        do_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 all ones", 1'b0);
        do_mul(32'h0001_2345, 32'hFFFF_FFFF, "R4 digits 1111", 1'b0);
        do_mul(32'h7FFF_FFFF, 32'hBBBB_BBBB, "R4 digits 1011", 1'b0);
        do_mul(32'h0F0F_1234, 32'hCCCC_4C4C, "R4 digits 1100", 1'b0);
        do_mul(32'h0000_0007, 32'hF000_0000, "R5 pending carry", 1'b0);
        do_mul(32'h8000_0001, 32'hB000_0000, "R5 carry with msb", 1'b0);
        do_mul(32'h8000_0000, 32'h0000_0001, "R6 msb only", 1'b0);
        do_mul(32'h8000_0000, 32'hFFFF_FFFF, "R6 msb only ones", 1'b0);
        do_mul(32'hC000_1234, 32'h8765_4321, "R6 msb set", 1'b0);
        do_mul(32'h0000_00FF, 32'h0000_000A, "R4 digit 10 no recode", 1'b0);
        do_mul(32'h1357_9BDF, 32'h2468_ACE0, "R7 start while busy", 1'b1);
        for (int i = 0; i < 200; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom();
            rb = $urandom();
            if (i % 4 == 0) ra[31] = 1'b1;
            if (i % 5 == 0) rb[31:28] = 4'hF;
            do_mul(ra, rb, "R1 random", 1'b0);
        end
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R7 outstanding items", 64'(exp_q.size()), 64'd0);
        check({prod_hi, prod_lo} == last_exp, "R8 idle hold", {prod_hi, prod_lo}, last_exp);
        finish_run();
    end
endmodule